// File: doc/BRIEF.md
# Sliced-Data Readback Register with Clear/Available Handshake

This block sits between a line-rate decoder of blanking-interval data and a slow host bus. On every video line the decoder gives a strobe, a flag saying whether the line carried data, and the decoded packet word. The host must arm the block with a one-cycle clear pulse. The next qualifying line event then loads the packet into a readback register, raises an available flag and pulses an interrupt request. After that the register stays frozen against later lines until the host clears it again. This lets the host read a coherent packet at its own pace.

A content-based-update mode is on after reset, and the host may change it through a small configuration write. In this mode the block reports only events that matter: a packet whose content differs from the last decoded one, the first packet after a period without data, or a loss of content. A loss of content is four consecutive empty lines after data had been arriving. On a loss the register reads as all zeros. When the mode is off, every decoded line after a clear is reported. A private shadow copy of the last decoded content is kept up to date on every data line, even while the readback register is frozen. Change detection uses this shadow copy.

Top module: `vbi_readback_reg`

## Requirements
- R1: After reset, avail, irq and rb_data are 0 and cb_enable is 1.
- R2: Before the first host_clear pulse, line events change neither avail nor rb_data.
- R3: After a host_clear, the next reportable line loads line_word into rb_data. avail reads 1 in the cycle after that strobe's clock edge.
- R4: While avail is 1, later line strobes change neither rb_data nor avail.
- R5: host_clear forces avail to 0 on the next cycle and leaves rb_data unchanged. A line strobe in the same cycle as host_clear is not captured.
- R6: With cb_enable = 1 and data arriving, a data line whose word equals the previous decoded word is not reported. A different word is reported.
- R7: Four consecutive empty lines (line_has_data = 0) after a data line are a loss. If armed, the loss sets rb_data to 0 and avail to 1. A data line within fewer than four empty lines restarts the count.
- R8: A loss is reported only once per episode. Further empty lines after a loss produce no event.
- R9: With cb_enable = 1, the first data line after a loss (or after reset) is reported, even if its word equals the last decoded word.
- R10: With cb_enable = 0, every data line after a host_clear is reported, even when the word is unchanged.
- R11: irq is a one-cycle pulse that is high exactly in the cycle when avail rises.
- R12: A cycle with cfg_wr = 1 loads cfg_cb_val into cb_enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle strobe per decoded line |
| line_has_data | input | 1 | Line carried valid data (qualifies line_stb) |
| line_word | input | DATA_W | Decoded packet content of the line |
| host_clear | input | 1 | Self-clearing arm/clear pulse from the host |
| cfg_wr | input | 1 | Write strobe for the update-mode setting |
| cfg_cb_val | input | 1 | Value written to the content-based-update enable |
| avail | output | 1 | Readback data valid |
| rb_data | output | DATA_W | Readback register |
| irq | output | 1 | Interrupt request pulse on each available event |
| cb_enable | output | 1 | Current content-based-update enable |

## Verification
The hardest state to reach from the ports is a loss report that must be distinguished from a count that was restarted. Reaching it takes an armed block, a prior data line, and exactly four empty strobes with no data line between them. The directed sequence first sends three empty lines and then an unchanged data word, which must produce no report. It then sends three empty lines, confirms nothing has happened, and sends a fourth. After re-arming, more empty lines follow to show that the episode is not reported twice. Then an unchanged word is sent, which must now count as new data.

// File: rtl/vbi_rb_pkg.sv
package vbi_rb_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_DATA = 2'd1,
        EV_LOSS = 2'd2
    } line_ev_e;

endpackage

// File: rtl/vbi_loss_tracker.sv
module vbi_loss_tracker #(
    parameter int LOSS_LINES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic line_has_data,
    output logic loss_evt,
    output logic receiving
);
    localparam int CNT_W = $clog2(LOSS_LINES + 1);
    localparam logic [CNT_W-1:0] LAST_EMPTY = CNT_W'(LOSS_LINES - 1);

    typedef struct packed {
        logic             recv;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d    = trk_q;
        loss_evt = 1'b0;
        if (line_stb) begin
            if (line_has_data) begin
                trk_d.cnt  = '0;
                trk_d.recv = 1'b1;
            end else if (trk_q.recv) begin
                trk_d.cnt = trk_q.cnt + 1'b1;
                if (trk_q.cnt == LAST_EMPTY) begin
                    loss_evt   = 1'b1;
                    trk_d.recv = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign receiving = trk_q.recv;
endmodule

// File: rtl/vbi_change_detect.sv
module vbi_change_detect #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              line_has_data,
    input  logic [DATA_W-1:0] line_word,
    output logic              changed
);
    logic [DATA_W-1:0] shadow_d, shadow_q;

    always_comb begin
        shadow_d = shadow_q;
        if (line_stb && line_has_data) shadow_d = line_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_d;
    end

    assign changed = (line_word != shadow_q);
endmodule

// File: rtl/vbi_readback_reg.sv
module vbi_readback_reg #(
    parameter int DATA_W     = 32,
    parameter int LOSS_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              line_has_data,
    input  logic [DATA_W-1:0] line_word,
    input  logic              host_clear,
    input  logic              cfg_wr,
    input  logic              cfg_cb_val,
    output logic              avail,
    output logic [DATA_W-1:0] rb_data,
    output logic              irq,
    output logic              cb_enable
);
    import vbi_rb_pkg::*;

    typedef struct packed {
        logic              armed;
        logic              avail;
        logic              irq;
        logic              cb_en;
        logic [DATA_W-1:0] data;
    } rb_st_t;

    rb_st_t st_d, st_q;
    logic loss_evt, receiving, changed;
    line_ev_e ev;

    vbi_loss_tracker #(.LOSS_LINES(LOSS_LINES)) u_loss (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
        .line_has_data(line_has_data),
        .loss_evt(loss_evt), .receiving(receiving)
    );

    vbi_change_detect #(.DATA_W(DATA_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
        .line_has_data(line_has_data), .line_word(line_word),
        .changed(changed)
    );

    // classify the current line
    always_comb begin
        ev = EV_NONE;
        if (line_stb) begin
            if (line_has_data) begin
                if (!st_q.cb_en || !receiving || changed) ev = EV_DATA;
            end else if (loss_evt) begin
                ev = EV_LOSS;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (cfg_wr) st_d.cb_en = cfg_cb_val;
        if (host_clear) begin
            st_d.armed = 1'b1;
            st_d.avail = 1'b0;
        end else if (st_q.armed && ev != EV_NONE) begin
            st_d.armed = 1'b0;
            st_d.avail = 1'b1;
            st_d.irq   = 1'b1;
            st_d.data  = (ev == EV_DATA) ? line_word : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cb_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign avail     = st_q.avail;
    assign rb_data   = st_q.data;
    assign irq       = st_q.irq;
    assign cb_enable = st_q.cb_en;
endmodule

// File: rtl/vbi_readback_chk.sv
module vbi_readback_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_stb,
    input logic              host_clear,
    input logic              avail,
    input logic              irq,
    input logic [DATA_W-1:0] rb_data
);
    // R11
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && !$past(avail)) |-> irq);
    // R11
    irq_needs_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (avail && !$past(avail)));
    // R4
    frozen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avail |=> $stable(rb_data));
    // R5
    clear_drops_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_clear |=> !avail);
    // R3
    rise_from_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail) |-> $past(line_stb));
    // R7
    data_moves_with_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rb_data) |-> $rose(avail));
endmodule

bind vbi_readback_reg vbi_readback_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .host_clear(host_clear),
    .avail(avail), .irq(irq), .rb_data(rb_data)
);

// File: tb/vbi_readback_reg_bench.sv
module vbi_readback_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_stb = 1'b0, line_has_data = 1'b0;
    logic [31:0] line_word = '0;
    logic        host_clear = 1'b0, cfg_wr = 1'b0, cfg_cb_val = 1'b0;
    logic        avail, irq, cb_enable;
    logic [31:0] rb_data;
    int          n_chk = 0, n_fail = 0;
    logic        irq_seen;

    always #10 clk = ~clk;

    vbi_readback_reg u_vbi_readback_reg (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_has_data(line_has_data),
        .line_word(line_word), .host_clear(host_clear), .cfg_wr(cfg_wr),
        .cfg_cb_val(cfg_cb_val), .avail(avail), .rb_data(rb_data), .irq(irq),
        .cb_enable(cb_enable)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_line(input logic has, input logic [31:0] w);
        @(negedge clk);
        line_stb = 1'b1; line_has_data = has; line_word = w;
        @(negedge clk);
        line_stb = 1'b0; line_has_data = 1'b0;
        irq_seen = irq;
    endtask

    task automatic do_clear();
        @(negedge clk);
        host_clear = 1'b1;
        @(negedge clk);
        host_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 avail", {31'd0, avail}, 32'd0);
        chk("R1 rb_data", rb_data, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 cb_enable", {31'd0, cb_enable}, 32'd1);
    endtask

    task automatic t_unarmed();
        send_line(1'b1, 32'hAAAA);
        chk("R2 avail", {31'd0, avail}, 32'd0);
        chk("R2 rb_data", rb_data, 32'd0);
    endtask

    task automatic t_capture();
        do_clear();
        send_line(1'b1, 32'h1111);
        chk("R3 avail", {31'd0, avail}, 32'd1);
        chk("R3 rb_data", rb_data, 32'h1111);
        chk("R11 irq pulse", {31'd0, irq_seen}, 32'd1);
        @(negedge clk);
        chk("R11 irq one cycle", {31'd0, irq}, 32'd0);
        send_line(1'b1, 32'h2222);
        chk("R4 frozen data", rb_data, 32'h1111);
        chk("R4 avail held", {31'd0, avail}, 32'd1);
        chk("R11 no irq frozen", {31'd0, irq_seen}, 32'd0);
    endtask

    task automatic t_clear_change();
        do_clear();
        chk("R5 avail low", {31'd0, avail}, 32'd0);
        chk("R5 data kept", rb_data, 32'h1111);
        send_line(1'b1, 32'h2222);
        chk("R6 same word ignored", {31'd0, avail}, 32'd0);
        send_line(1'b1, 32'h3333);
        chk("R6 changed avail", {31'd0, avail}, 32'd1);
        chk("R6 changed data", rb_data, 32'h3333);
    endtask

    task automatic t_loss();
        do_clear();
        repeat (3) send_line(1'b0, 32'h0);
        send_line(1'b1, 32'h3333);
        chk("R7 count restart", {31'd0, avail}, 32'd0);
        repeat (3) send_line(1'b0, 32'h0);
        chk("R7 three empty", {31'd0, avail}, 32'd0);
        send_line(1'b0, 32'h0);
        chk("R7 loss avail", {31'd0, avail}, 32'd1);
        chk("R7 loss zero", rb_data, 32'h0);
        chk("R11 loss irq", {31'd0, irq_seen}, 32'd1);
        do_clear();
        repeat (5) send_line(1'b0, 32'h0);
        chk("R8 single loss", {31'd0, avail}, 32'd0);
        send_line(1'b1, 32'h3333);
        chk("R9 new data avail", {31'd0, avail}, 32'd1);
        chk("R9 new data word", rb_data, 32'h3333);
    endtask

    task automatic t_clear_vs_line();
        @(negedge clk);
        host_clear = 1'b1; line_stb = 1'b1; line_has_data = 1'b1; line_word = 32'h4444;
        @(negedge clk);
        host_clear = 1'b0; line_stb = 1'b0; line_has_data = 1'b0;
        chk("R5 clear wins avail", {31'd0, avail}, 32'd0);
        chk("R5 clear wins data", rb_data, 32'h3333);
    endtask

    task automatic t_cb_off();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_cb_val = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R12 cb off", {31'd0, cb_enable}, 32'd0);
        send_line(1'b1, 32'h4444);
        chk("R10 same word reported", {31'd0, avail}, 32'd1);
        chk("R10 data", rb_data, 32'h4444);
        do_clear();
        send_line(1'b1, 32'h4444);
        chk("R10 repeat reported", {31'd0, avail}, 32'd1);
        chk("R11 repeat irq", {31'd0, irq_seen}, 32'd1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_cb_val = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R12 cb on", {31'd0, cb_enable}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unarmed();
        t_capture();
        t_clear_change();
        t_loss();
        t_clear_vs_line();
        t_cb_off();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule